// File: doc/BRIEF.md
# UART Interrupt Prioritizer with Receive Character Timeout

This block decides which interrupt a UART presents to its host. It collects six sources: line status errors, receive data at the trigger level, receive character timeout, transmit holding register empty, modem status change, and special character match. It then reports only the most urgent enabled one as a 3-bit identification code. Sources that lose the arbitration stay latched and appear in turn once the winner has been serviced. A single interrupt output is high whenever any enabled source is pending.

The block also holds the receive character-timeout counter. The counter advances on a x16 baud tick while the receive FIFO holds data. Its limit is four character times, worked out from the current frame format: word length, parity and stop-bit setting. It restarts at the centre of each received stop bit and on every read of the receive holding register. Register decoding and the FIFOs live outside; the block sees only strobes, counts and settings.

Top module: `uart_irq_arbiter`

## Requirements
- R1: After synchronous reset, with all enables clear, `irq` is 0 and `irq_id` is 0 (none).
- R2: Priority from highest to lowest: line status (id 1), receive timeout (id 3) / receive data (id 2), transmit empty (id 4), modem status (id 5), special character (id 6). Enable bits are: 0 receive, 1 transmit empty, 2 line, 3 modem, 4 special.
- R3: A pending source that loses the arbitration stays pending and is reported once the higher sources have been cleared.
- R4: The transmit-empty source is pending right after reset, so setting enable bit 1 raises it at once. It clears when `thr_empty` is low, or when `iid_read` is pulsed while id 4 is reported. It is set again on a rising edge of `thr_empty`.
- R5: Receive data (id 2) is reported while `rx_count` is nonzero and `rx_count >= rx_trigger`, under enable bit 0.
- R6: A receive timeout never becomes pending while `rx_count` is zero.
- R7: The timeout counter restarts on `stop_mid` and on `rhr_read`, and `rhr_read` clears a pending timeout.
- R8: A timeout becomes pending on the baud tick that completes 4 character times. One character is (1 start + data bits + parity bit if enabled) × 16 ticks, plus 16 ticks for one stop bit. When `long_stop` is set, the stop part is 24 ticks for 5-bit words and 32 ticks otherwise. Word length code `wlen` 0..3 selects 5..8 data bits.
- R9: `irq` is 1 exactly when `irq_id` is not 0.
- R10: A source whose enable is clear is not reported but stays latched, and it is reported once enabled.
- R11: `lsr_read` clears the line source, `msr_read` clears the modem source, and `iid_read` clears the special source while id 6 is reported.
- R12: Receive timeout and receive data share one level, both under enable bit 0. When both are pending, the timeout (id 3) is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_en | input | 5 | Source enables (bit 0 rx, 1 tx empty, 2 line, 3 modem, 4 special) |
| rx_count | input | LVL_W | Receive FIFO fill level |
| rx_trigger | input | LVL_W | Receive trigger level |
| thr_empty | input | 1 | Transmit holding register empty status |
| line_evt | input | 1 | Line status error event pulse |
| lsr_read | input | 1 | Line status read strobe |
| modem_evt | input | 1 | Modem status change pulse |
| msr_read | input | 1 | Modem status read strobe |
| special_evt | input | 1 | Special character match pulse |
| iid_read | input | 1 | Interrupt identification read strobe |
| baud_tick | input | 1 | x16 baud tick |
| wlen | input | 2 | Word length code (0..3 = 5..8 bits) |
| par_en | input | 1 | Parity bit present |
| long_stop | input | 1 | 1.5 / 2 stop bits selected |
| stop_mid | input | 1 | Centre of received stop bit strobe |
| rhr_read | input | 1 | Receive holding register read strobe |
| irq | output | 1 | Interrupt request |
| irq_id | output | 3 | Highest-priority pending source code |

## Verification
Some properties are checked on every cycle: the output agreement between `irq` and `irq_id`, line status winning whenever it is enabled, and the clearing of the line and transmit sources by their strobes. They also cover the timeout never being pending with an empty FIFO, being dropped by a holding-register read, and rising only when the count has reached the format's limit. The exact tick at which a timeout appears for each frame format, and the restart by a stop-bit strobe, can only be shown by the bench's scenarios. The same holds for the order in which stacked sources surface as each is serviced, and for latched but disabled sources showing up once enabled.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef enum logic [2:0] {
        ID_NONE      = 3'd0,
        ID_LINE      = 3'd1,
        ID_RXDATA    = 3'd2,
        ID_RXTIMEOUT = 3'd3,
        ID_THRE      = 3'd4,
        ID_MODEM     = 3'd5,
        ID_SPECIAL   = 3'd6
    } irq_id_e;

    localparam int unsigned EN_RX      = 0;
    localparam int unsigned EN_THR     = 1;
    localparam int unsigned EN_LINE    = 2;
    localparam int unsigned EN_MODEM   = 3;
    localparam int unsigned EN_SPECIAL = 4;
    localparam int unsigned EN_W       = 5;

    localparam logic [1:0] WLEN_5 = 2'd0;

    typedef struct packed {
        logic [1:0] wlen;
        logic       par_en;
        logic       long_stop;
    } frame_cfg_t;

    typedef struct packed {
        logic line;
        logic rxto;
        logic rxdata;
        logic thre;
        logic modem;
        logic special;
    } src_pend_t;

    // Ticks in one character: start, data, optional parity, stop part.
    function automatic logic [15:0] char_ticks(frame_cfg_t f, int unsigned tpb);
        logic [15:0] nbits;
        logic [15:0] t;
        nbits = 16'd6 + {14'd0, f.wlen};
        if (f.par_en) nbits = nbits + 16'd1;
        t = nbits * 16'(tpb);
        if (!f.long_stop)
            t = t + 16'(tpb);
        else if (f.wlen == WLEN_5)
            t = t + 16'(tpb + tpb / 2);
        else
            t = t + 16'(2 * tpb);
        return t;
    endfunction

    function automatic logic [15:0] timeout_ticks(frame_cfg_t f, int unsigned tpb);
        return char_ticks(f, tpb) << 2;
    endfunction

    // Worst case: 12 bit times per char, four chars.
    function automatic int unsigned max_timeout(int unsigned tpb);
        return 48 * tpb;
    endfunction

endpackage

// File: rtl/uart_rx_timeout.sv
module uart_rx_timeout
    import uart_irq_pkg::*;
#(
    parameter int unsigned TICKS_PER_BIT = 16,
    parameter int unsigned CNT_W = $clog2(max_timeout(TICKS_PER_BIT) + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  frame_cfg_t cfg,
    input  logic       baud_tick,
    input  logic       stop_mid,
    input  logic       rhr_read,
    input  logic       fifo_empty,
    output logic       to_pend
);

    logic [15:0]      limit_full;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] cnt;
    logic             restart;

    assign limit_full = timeout_ticks(cfg, TICKS_PER_BIT);
    assign limit      = limit_full[CNT_W-1:0];
    assign restart    = stop_mid || rhr_read;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            to_pend <= 1'b0;
        end else if (fifo_empty) begin
            cnt     <= '0;
            to_pend <= 1'b0;
        end else begin
            if (rhr_read) to_pend <= 1'b0;
            if (restart) begin
                cnt <= '0;
            end else if (baud_tick && !to_pend) begin
                if (cnt >= limit - 1'b1) begin
                    to_pend <= 1'b1;
                    cnt     <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assert_no_timeout_empty_R6: assert property (@(posedge clk) disable iff (rst)
        fifo_empty |=> !to_pend);

    assert_read_drops_timeout_R7: assert property (@(posedge clk) disable iff (rst)
        rhr_read |=> !to_pend);

    assert_timeout_at_limit_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(to_pend) |-> ($past(cnt) >= $past(limit) - 1'b1));

endmodule

// File: rtl/uart_irq_sources.sv
module uart_irq_sources
    import uart_irq_pkg::*;
#(
    parameter int unsigned LVL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] rx_count,
    input  logic [LVL_W-1:0] rx_trigger,
    input  logic             thr_empty,
    input  logic             line_evt,
    input  logic             lsr_read,
    input  logic             modem_evt,
    input  logic             msr_read,
    input  logic             special_evt,
    input  logic             iid_read,
    input  logic             to_pend,
    input  irq_id_e          cur_id,
    output src_pend_t        pend
);

    logic line_q, modem_q, special_q, thre_q, thr_empty_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q      <= 1'b0;
            modem_q     <= 1'b0;
            special_q   <= 1'b0;
            thre_q      <= 1'b1;
            thr_empty_q <= 1'b1;
        end else begin
            thr_empty_q <= thr_empty;

            if (line_evt)      line_q <= 1'b1;
            else if (lsr_read) line_q <= 1'b0;

            if (modem_evt)     modem_q <= 1'b1;
            else if (msr_read) modem_q <= 1'b0;

            if (special_evt)                              special_q <= 1'b1;
            else if (iid_read && cur_id == ID_SPECIAL)    special_q <= 1'b0;

            if (!thr_empty)                               thre_q <= 1'b0;
            else if (!thr_empty_q)                        thre_q <= 1'b1;
            else if (iid_read && cur_id == ID_THRE)       thre_q <= 1'b0;
        end
    end

    always_comb begin
        pend.line    = line_q;
        pend.rxto    = to_pend;
        pend.rxdata  = (rx_count != '0) && (rx_count >= rx_trigger);
        pend.thre    = thre_q;
        pend.modem   = modem_q;
        pend.special = special_q;
    end

    assert_lsr_clears_line_R11: assert property (@(posedge clk) disable iff (rst)
        (lsr_read && !line_evt) |=> !pend.line);

    assert_thr_low_clears_R4: assert property (@(posedge clk) disable iff (rst)
        !thr_empty |=> !pend.thre);

endmodule

// File: rtl/uart_irq_select.sv
module uart_irq_select
    import uart_irq_pkg::*;
(
    input  src_pend_t         pend,
    input  logic [EN_W-1:0]   en,
    output irq_id_e           id
);

    always_comb begin
        if (pend.line && en[EN_LINE])
            id = ID_LINE;
        else if (pend.rxto && en[EN_RX])
            id = ID_RXTIMEOUT;
        else if (pend.rxdata && en[EN_RX])
            id = ID_RXDATA;
        else if (pend.thre && en[EN_THR])
            id = ID_THRE;
        else if (pend.modem && en[EN_MODEM])
            id = ID_MODEM;
        else if (pend.special && en[EN_SPECIAL])
            id = ID_SPECIAL;
        else
            id = ID_NONE;
    end

endmodule

// File: rtl/uart_irq_arbiter.sv
module uart_irq_arbiter
    import uart_irq_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH    = 128,
    parameter int unsigned TICKS_PER_BIT = 16,
    parameter int unsigned LVL_W         = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [4:0]       irq_en,
    input  logic [LVL_W-1:0] rx_count,
    input  logic [LVL_W-1:0] rx_trigger,
    input  logic             thr_empty,
    input  logic             line_evt,
    input  logic             lsr_read,
    input  logic             modem_evt,
    input  logic             msr_read,
    input  logic             special_evt,
    input  logic             iid_read,
    input  logic             baud_tick,
    input  logic [1:0]       wlen,
    input  logic             par_en,
    input  logic             long_stop,
    input  logic             stop_mid,
    input  logic             rhr_read,
    output logic             irq,
    output logic [2:0]       irq_id
);

    frame_cfg_t cfg;
    src_pend_t  pend;
    irq_id_e    cur_id;
    logic       to_pend;

    assign cfg = '{wlen: wlen, par_en: par_en, long_stop: long_stop};

    uart_rx_timeout #(
        .TICKS_PER_BIT(TICKS_PER_BIT)
    ) u_timeout (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg),
        .baud_tick (baud_tick),
        .stop_mid  (stop_mid),
        .rhr_read  (rhr_read),
        .fifo_empty(rx_count == '0),
        .to_pend   (to_pend)
    );

    uart_irq_sources #(
        .LVL_W(LVL_W)
    ) u_sources (
        .clk        (clk),
        .rst        (rst),
        .rx_count   (rx_count),
        .rx_trigger (rx_trigger),
        .thr_empty  (thr_empty),
        .line_evt   (line_evt),
        .lsr_read   (lsr_read),
        .modem_evt  (modem_evt),
        .msr_read   (msr_read),
        .special_evt(special_evt),
        .iid_read   (iid_read),
        .to_pend    (to_pend),
        .cur_id     (cur_id),
        .pend       (pend)
    );

    uart_irq_select u_select (
        .pend(pend),
        .en  (irq_en),
        .id  (cur_id)
    );

    assign irq_id = cur_id;
    assign irq    = (cur_id != ID_NONE);

    assert_irq_matches_id_R9: assert property (@(posedge clk) disable iff (rst)
        irq == (irq_id != 3'd0));

    assert_line_wins_R2: assert property (@(posedge clk) disable iff (rst)
        (pend.line && irq_en[EN_LINE]) |-> (irq_id == 3'd1));

    assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (irq_en == 5'd0) |-> !irq);

endmodule

// File: tb/uart_irq_arbiter_bench.sv
module uart_irq_arbiter_bench;

    localparam int CLK_PERIOD = 10;
    localparam int LVL_W = 8;

    logic clk = 1'b0;
    logic rst;
    logic [4:0] irq_en;
    logic [LVL_W-1:0] rx_count, rx_trigger;
    logic thr_empty, line_evt, lsr_read, modem_evt, msr_read;
    logic special_evt, iid_read, baud_tick;
    logic [1:0] wlen;
    logic par_en, long_stop, stop_mid, rhr_read;
    logic irq;
    logic [2:0] irq_id;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_irq_arbiter u_uart_irq_arbiter (
        .clk(clk), .rst(rst), .irq_en(irq_en), .rx_count(rx_count),
        .rx_trigger(rx_trigger), .thr_empty(thr_empty), .line_evt(line_evt),
        .lsr_read(lsr_read), .modem_evt(modem_evt), .msr_read(msr_read),
        .special_evt(special_evt), .iid_read(iid_read), .baud_tick(baud_tick),
        .wlen(wlen), .par_en(par_en), .long_stop(long_stop),
        .stop_mid(stop_mid), .rhr_read(rhr_read), .irq(irq), .irq_id(irq_id)
    );

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk_id(string req, logic [2:0] exp);
        #1;
        n_checks++;
        if (irq_id !== exp || irq !== (exp != 3'd0)) begin
            n_fail++;
            $display("FAIL %s: irq_id actual %0d expected %0d (irq %0b)", req, irq_id, exp, irq);
        end
    endtask

    task automatic pulse(ref logic s);
        s = 1'b1;
        step(1);
        s = 1'b0;
    endtask

    task automatic t_reset_and_thr;
        chk_id("R1 reset none", 3'd0);
        irq_en = 5'b00010;
        chk_id("R4 thr after reset", 3'd4);
        pulse(iid_read);
        chk_id("R4 iid read clears thr", 3'd0);
        thr_empty = 1'b0; step(1);
        thr_empty = 1'b1; step(1);
        chk_id("R4 thr rising sets", 3'd4);
        thr_empty = 1'b0; step(1);
        chk_id("R4 thr low clears", 3'd0);
    endtask

    task automatic t_priority;
        irq_en = 5'b11111;
        thr_empty = 1'b1; step(1);
        line_evt = 1'b1; modem_evt = 1'b1; special_evt = 1'b1; step(1);
        line_evt = 1'b0; modem_evt = 1'b0; special_evt = 1'b0;
        rx_trigger = 8'd4; rx_count = 8'd5;
        chk_id("R2 line highest", 3'd1);
        pulse(lsr_read);
        chk_id("R3 rx data surfaces", 3'd2);
        rx_count = 8'd0;
        chk_id("R3 thr surfaces", 3'd4);
        pulse(iid_read);
        chk_id("R3 modem surfaces", 3'd5);
        pulse(msr_read);
        chk_id("R11 special after modem clear", 3'd6);
        pulse(iid_read);
        chk_id("R9 all clear", 3'd0);
        thr_empty = 1'b0; step(1);
    endtask

    task automatic t_disabled;
        irq_en = 5'b00000;
        pulse(line_evt);
        chk_id("R10 disabled line hidden", 3'd0);
        irq_en = 5'b00100;
        chk_id("R10 enable shows latched line", 3'd1);
        pulse(lsr_read);
        chk_id("R11 lsr read clears line", 3'd0);
    endtask

    task automatic t_rx_trigger;
        irq_en = 5'b00001;
        rx_trigger = 8'd8; rx_count = 8'd7;
        chk_id("R5 below trigger", 3'd0);
        rx_count = 8'd8;
        chk_id("R5 at trigger", 3'd2);
        rx_trigger = 8'd0; rx_count = 8'd0;
        chk_id("R5 empty zero trigger", 3'd0);
        rx_count = 8'd1;
        chk_id("R5 one char zero trigger", 3'd2);
        rx_count = 8'd0;
        step(1);
    endtask

    task automatic t_timeout(logic [1:0] w, logic p, logic ls, int lim, string tag);
        irq_en = 5'b00001;
        wlen = w; par_en = p; long_stop = ls;
        rx_trigger = 8'd16; rx_count = 8'd1; baud_tick = 1'b1;
        pulse(rhr_read);
        step(lim - 1);
        chk_id({"R8 not yet ", tag}, 3'd0);
        step(1);
        chk_id({"R8 fires ", tag}, 3'd3);
        rx_count = 8'd20;
        chk_id({"R12 timeout over data ", tag}, 3'd3);
        pulse(rhr_read);
        chk_id({"R7 read clears timeout ", tag}, 3'd2);
        rx_count = 8'd0; baud_tick = 1'b0;
        step(1);
    endtask

    task automatic t_restart;
        irq_en = 5'b00001;
        wlen = 2'd0; par_en = 1'b0; long_stop = 1'b0;
        rx_trigger = 8'd16; rx_count = 8'd1; baud_tick = 1'b1;
        pulse(rhr_read);
        step(300);
        pulse(stop_mid);
        step(447);
        chk_id("R7 stop centre restarts", 3'd0);
        step(1);
        chk_id("R7 fires after restart", 3'd3);
        pulse(rhr_read);
        rx_count = 8'd0;
        step(1);
        step(1000);
        chk_id("R6 no timeout when empty", 3'd0);
        baud_tick = 1'b0;
    endtask

    initial begin
        rst = 1'b1; irq_en = '0; rx_count = '0; rx_trigger = '0;
        thr_empty = 1'b1; line_evt = 0; lsr_read = 0; modem_evt = 0;
        msr_read = 0; special_evt = 0; iid_read = 0; baud_tick = 0;
        wlen = 0; par_en = 0; long_stop = 0; stop_mid = 0; rhr_read = 0;
        step(3);
        rst = 1'b0;
        t_reset_and_thr();
        t_priority();
        t_disabled();
        t_rx_trigger();
        t_timeout(2'd0, 1'b0, 1'b0, 448, "5n1");
        t_timeout(2'd3, 1'b1, 1'b1, 768, "8p2");
        t_timeout(2'd0, 1'b0, 1'b1, 480, "5n1.5");
        t_timeout(2'd2, 1'b1, 1'b0, 640, "7p1");
        t_restart();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule